// File: doc/BRIEF.md
# Watchdog Timer With Reset Sequencer

This block is an 8-bit watchdog counter with a reset sequencer behind it. Software sets three control bits and services the timer by writing 0x00 to the counter. While the timer is enabled and set to watchdog mode, the counter advances on each cycle where the prescaler's count-enable input is high.

When the counter wraps from its all-ones value to zero, a select bit decides what happens:

- **NMI mode:** the block raises a one-cycle non-maskable interrupt request, and the counter keeps running.
- **Reset mode:** the block starts a reset sequence. This drives an internal reset for a long window and, from the same clock edge, an active-low external reset output for a shorter window.

An overflow flag records that a wrap has happened. A source flag tells a reset that came from the external pin apart from one that came from the watchdog. The pin wins when both occur in the same cycle.

There is no data stream at this block's edge. The write port, the count enable and every output are plain control and status pins with no valid/ready handshake. A write completes in the cycle it is presented, and nothing applies back-pressure.

Top module: `wdog_guard`

## Requirements
- R1: In reset mode, an overflow raises `core_rst` at the next clock edge and holds it high for exactly RST_CYCLES (default 518) clock cycles. Reset mode means control bit 2 = 1.
- R2: The same overflow drives `ext_rst_n_o` low from that same clock edge for exactly EXT_CYCLES (default 132) clock cycles, after which it returns high.
- R3: In NMI mode, an overflow pulses `nmi_req`. `ext_rst_n_o` stays high and `core_rst` stays low. NMI mode means control bit 2 = 0.
- R4: `nmi_req` is high for one cycle per overflow. In NMI mode the counter keeps wrapping, so each further 256 count-enable cycles give one more pulse.
- R5: `ovf_flag` becomes 1 at the edge where the counter overflows, in either mode. It stays 1 until a pin reset, or until the edge where a watchdog reset sequence ends.
- R6: `pin_src_flag` is 1 after a pin reset. It becomes 0 at the edge where a watchdog reset sequence starts.
- R7: If `pin_rst_n` is low in the same cycle as an overflow in reset mode, the pin reset wins: no sequence starts and `pin_src_flag` is 1.
- R8: The counter advances only on cycles where all three of these hold:
  - `cnt_tick` = 1;
  - the enable bit (control bit 0) = 1;
  - the mode bit (control bit 1) = 1, which selects watchdog mode. A value of 0 selects interval mode, in which the counter holds.
- R9: Writes use `wr_en`. With `wr_sel` = 0 a write loads the counter from `wr_data`; with `wr_sel` = 1 it loads the control bits from `wr_data[2:0]`. A counter write takes precedence over a count in the same cycle.
- R10: While a watchdog reset sequence is active, writes are ignored. The watchdog reset also clears the control bits, so the counter stays stopped after the sequence ends.
- R11: While `pin_rst_n` is low, the block clears the counter, the control bits, the sequencer and `ovf_flag`. It also holds the outputs at `core_rst` = 0, `ext_rst_n_o` = 1 and `nmi_req` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| pin_rst_n | input | 1 | External reset pin, active low, sampled synchronously |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 = counter, 1 = control bits |
| wr_data | input | CNT_W | Write data |
| cnt_tick | input | 1 | Prescaled count enable |
| core_rst | output | 1 | Internal reset, active high |
| ext_rst_n_o | output | 1 | External reset output, active low |
| nmi_req | output | 1 | Non-maskable interrupt request pulse |
| ovf_flag | output | 1 | Overflow flag |
| pin_src_flag | output | 1 | Reset source: 1 = pin, 0 = watchdog |

## Verification
The overflow path is driven by presetting the counter and then issuing runs of count-enable cycles. Each run is one of three lengths:

- exactly enough ticks to wrap, which separates a correct terminal count from an off-by-one;
- one tick short of a wrap;
- a full 256-tick wrap or longer, which shows that NMI mode keeps counting.

The same runs are repeated with the timer disabled, in interval mode, and with the reset select set without watchdog mode, so a wrong enable decode shows up as a stray event. Every run also counts how many cycles the internal and external resets are active. This tells an exact pulse length apart from a retriggered or truncated one. Directed cases cover the tie with the pin, a write in the same cycle as a count, and writes during the sequence.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  // control bits as held inside the block; bit order follows the write data
  typedef struct packed {
    logic rst_sel;   // bit 2: 1 = reset on overflow, 0 = NMI
    logic wd_mode;   // bit 1: 1 = watchdog mode, 0 = interval mode
    logic run_en;    // bit 0: timer enable
  } wdog_ctrl_t;

  localparam int unsigned CTRL_W = 3;
endpackage

// File: rtl/wdog_counter.sv
module wdog_counter
  import wdog_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             clr,       // pin reset, synchronous
  input  logic             fire,      // watchdog reset starts this cycle
  input  logic             hold,      // watchdog reset sequence active
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             tick,
  output logic             ovf_evt,
  output wdog_ctrl_t       ctrl_o
);
  localparam logic [CNT_W-1:0] TOP = '1;

  logic [CNT_W-1:0] cnt_q;
  wdog_ctrl_t       ctrl_q;
  logic             running;
  logic             cnt_wr;
  logic             ctl_wr;

  assign running = ctrl_q.run_en & ctrl_q.wd_mode;
  assign cnt_wr  = wr_en & ~wr_sel & ~hold;
  assign ctl_wr  = wr_en &  wr_sel & ~hold;
  assign ovf_evt = running & tick & ~cnt_wr & (cnt_q == TOP);
  assign ctrl_o  = ctrl_q;

  always_ff @(posedge clk) begin
    if (clr) begin
      cnt_q  <= '0;
      ctrl_q <= '0;
    end else if (fire) begin
      cnt_q  <= '0;
      ctrl_q <= '0;
    end else if (!hold) begin
      if (cnt_wr)
        cnt_q <= wr_data;
      else if (running && tick)
        cnt_q <= cnt_q + 1'b1;
      if (ctl_wr)
        ctrl_q <= wdog_ctrl_t'(wr_data[CTRL_W-1:0]);
    end
  end

  // R10: a running sequence keeps the counter and control cleared
  assert_hold_clear_R10: assert property (@(posedge clk) disable iff (clr)
    hold |=> (cnt_q == '0 && ctrl_q == '0));

  // R8: no write and no qualified tick leaves the count unchanged
  assert_no_count_R8: assert property (@(posedge clk) disable iff (clr)
    (!fire && !cnt_wr && !(running && tick)) |=> $stable(cnt_q));
endmodule

// File: rtl/wdog_pulse_timer.sv
module wdog_pulse_timer #(
  parameter int unsigned LEN = 518,
  parameter int unsigned CW  = $clog2(LEN + 1)
) (
  input  logic clk,
  input  logic clr,
  input  logic start,
  output logic active,
  output logic last
);
  logic [CW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (clr)
      left_q <= '0;
    else if (start)
      left_q <= CW'(LEN);
    else if (left_q != '0)
      left_q <= left_q - 1'b1;
  end

  assign active = (left_q != '0);
  assign last   = (left_q == CW'(1));

  // R1: a start arms the pulse at the next edge
  assert_pulse_arm_R1: assert property (@(posedge clk) disable iff (clr)
    start |=> active);

  // R2: the pulse stops one edge after its final cycle unless restarted
  assert_pulse_stop_R2: assert property (@(posedge clk) disable iff (clr)
    (last && !start) |=> !active);
endmodule

// File: rtl/wdog_guard.sv
module wdog_guard
  import wdog_pkg::*;
#(
  parameter int unsigned CNT_W      = 8,
  parameter int unsigned RST_CYCLES = 518,
  parameter int unsigned EXT_CYCLES = 132
) (
  input  logic             clk,
  input  logic             pin_rst_n,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             cnt_tick,
  output logic             core_rst,
  output logic             ext_rst_n_o,
  output logic             nmi_req,
  output logic             ovf_flag,
  output logic             pin_src_flag
);
  localparam int unsigned NUM_PULSE = 2;
  localparam int unsigned MAX_LEN   = (RST_CYCLES > EXT_CYCLES) ? RST_CYCLES : EXT_CYCLES;
  localparam int unsigned TW        = $clog2(MAX_LEN + 1);
  localparam int unsigned PULSE_LEN [NUM_PULSE] = '{RST_CYCLES, EXT_CYCLES};

  logic       clr;
  logic       ovf_evt;
  logic       wd_start;
  wdog_ctrl_t ctrl;
  logic [NUM_PULSE-1:0] p_act;
  logic [NUM_PULSE-1:0] p_last;

  assign clr      = ~pin_rst_n;
  // the pin has priority: an overflow seen while the pin is low starts nothing
  assign wd_start = ovf_evt & pin_rst_n & ctrl.rst_sel;

  wdog_counter #(.CNT_W(CNT_W)) u_count (
    .clk     (clk),
    .clr     (clr),
    .fire    (wd_start),
    .hold    (core_rst),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .tick    (cnt_tick),
    .ovf_evt (ovf_evt),
    .ctrl_o  (ctrl)
  );

  // index 0 times the internal reset, index 1 the external pin pulse
  for (genvar g = 0; g < NUM_PULSE; g++) begin : g_pulse
    wdog_pulse_timer #(.LEN(PULSE_LEN[g]), .CW(TW)) u_timer (
      .clk    (clk),
      .clr    (clr),
      .start  (wd_start),
      .active (p_act[g]),
      .last   (p_last[g])
    );
  end

  assign core_rst    = p_act[0];
  assign ext_rst_n_o = ~p_act[1];

  always_ff @(posedge clk) begin
    if (clr) begin
      nmi_req      <= 1'b0;
      ovf_flag     <= 1'b0;
      pin_src_flag <= 1'b1;
    end else begin
      nmi_req <= ovf_evt & ~ctrl.rst_sel;
      if (ovf_evt)
        ovf_flag <= 1'b1;
      else if (p_last[0])
        ovf_flag <= 1'b0;
      if (wd_start)
        pin_src_flag <= 1'b0;
    end
  end

  // R2: the external pulse lies inside the internal reset window
  assert_ext_inside_R2: assert property (@(posedge clk) disable iff (clr)
    !ext_rst_n_o |-> core_rst);

  // R2: the external pin is released after its last cycle
  assert_ext_release_R2: assert property (@(posedge clk) disable iff (clr)
    (p_last[1] && !wd_start) |=> ext_rst_n_o);

  // R3: an NMI never comes with a reset pulse
  assert_nmi_quiet_R3: assert property (@(posedge clk) disable iff (clr)
    nmi_req |-> (ext_rst_n_o && !core_rst));

  // R4: the NMI request lasts one cycle
  assert_nmi_single_R4: assert property (@(posedge clk) disable iff (clr)
    nmi_req |=> !nmi_req);

  // R5: an overflow sets the flag
  assert_ovf_set_R5: assert property (@(posedge clk) disable iff (clr)
    ovf_evt |=> ovf_flag);

  // R6: a watchdog reset marks the source as the watchdog
  assert_src_wdog_R6: assert property (@(posedge clk) disable iff (clr)
    wd_start |=> !pin_src_flag);

  // R7 and R11: a low pin leaves the source flag set and no reset running
  assert_pin_wins_R7: assert property (@(posedge clk)
    !pin_rst_n |=> (pin_src_flag && !core_rst && ext_rst_n_o && !nmi_req));
endmodule

// File: tb/wdog_guard_bench.sv
module wdog_guard_bench;
  localparam int unsigned CNT_W = 8;
  localparam int RST_LEN = 518;
  localparam int EXT_LEN = 132;

  logic             clk = 1'b0;
  logic             pin_rst_n = 1'b0;
  logic             wr_en = 1'b0;
  logic             wr_sel = 1'b0;
  logic [CNT_W-1:0] wr_data = '0;
  logic             cnt_tick = 1'b0;
  logic             core_rst, ext_rst_n_o, nmi_req, ovf_flag, pin_src_flag;

  int n_checks = 0;
  int n_fail   = 0;
  int core_cnt = 0;
  int ext_cnt  = 0;
  int nmi_cnt  = 0;

  always #5 clk = ~clk;

  wdog_guard #(.CNT_W(CNT_W), .RST_CYCLES(RST_LEN), .EXT_CYCLES(EXT_LEN)) u_wdog_guard (
    .clk(clk), .pin_rst_n(pin_rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .cnt_tick(cnt_tick), .core_rst(core_rst),
    .ext_rst_n_o(ext_rst_n_o), .nmi_req(nmi_req), .ovf_flag(ovf_flag),
    .pin_src_flag(pin_src_flag)
  );

  // tally outputs 2 ns after each rising edge
  always @(posedge clk) begin
    #2;
    if (core_rst)     core_cnt++;
    if (!ext_rst_n_o) ext_cnt++;
    if (nmi_req)      nmi_cnt++;
  end

  // ctrl bits: [2] reset select, [1] watchdog mode, [0] enable
  typedef struct packed {
    logic [2:0] ctrl;
    logic [7:0] preload;
    logic [9:0] ticks;
    logic [1:0] nmis;
    logic       core;
    logic       ovf;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{3'b011, 8'hFD, 10'd3,   2'd1, 1'b0, 1'b1},  // R3 NMI on exact wrap
    '{3'b011, 8'hFD, 10'd2,   2'd0, 1'b0, 1'b0},  // R8 one short
    '{3'b001, 8'hF0, 10'd40,  2'd0, 1'b0, 1'b0},  // R8 interval mode
    '{3'b010, 8'hF0, 10'd40,  2'd0, 1'b0, 1'b0},  // R8 disabled
    '{3'b111, 8'hFE, 10'd2,   2'd0, 1'b1, 1'b0},  // R1 reset sequence
    '{3'b111, 8'hFE, 10'd1,   2'd0, 1'b0, 1'b0},  // R1 one short
    '{3'b011, 8'h00, 10'd256, 2'd1, 1'b0, 1'b1},  // R4 full wrap
    '{3'b011, 8'hF0, 10'd272, 2'd2, 1'b0, 1'b1},  // R4 two wraps
    '{3'b101, 8'hFE, 10'd5,   2'd0, 1'b0, 1'b0}   // R8 reset select, interval mode
  };

  task automatic check(input string what, input int actual, input int expected);
    n_checks++;
    if (actual != expected) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", what, actual, expected);
    end
  endtask

  task automatic pin_reset();
    @(negedge clk);
    pin_rst_n = 1'b0;
    repeat (3) @(negedge clk);
    pin_rst_n = 1'b1;
  endtask

  task automatic do_write(input logic sel, input logic [CNT_W-1:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic give_ticks(input int n);
    repeat (n) begin
      @(negedge clk);
      cnt_tick = 1'b1;
    end
    @(negedge clk);
    cnt_tick = 1'b0;
  endtask

  task automatic clear_tally();
    core_cnt = 0; ext_cnt = 0; nmi_cnt = 0;
  endtask

  initial begin
    #1_900_000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    // R11 reset state while the pin is low
    repeat (3) @(negedge clk);
    check("R11 core_rst in pin reset", core_rst, 0);
    check("R11 ext_rst_n_o in pin reset", ext_rst_n_o, 1);
    check("R11 nmi_req in pin reset", nmi_req, 0);
    check("R11 ovf_flag in pin reset", ovf_flag, 0);
    check("R6 src flag in pin reset", pin_src_flag, 1);
    pin_rst_n = 1'b1;

    // table walk
    for (int i = 0; i < NV; i++) begin
      pin_reset();
      do_write(1'b1, CNT_W'(VECS[i].ctrl));
      do_write(1'b0, VECS[i].preload);
      clear_tally();
      give_ticks(int'(VECS[i].ticks));
      repeat (560) @(negedge clk);
      check($sformatf("R3/R4 vec%0d nmi pulses", i), nmi_cnt, int'(VECS[i].nmis));
      check($sformatf("R1 vec%0d core_rst cycles", i), core_cnt, VECS[i].core ? RST_LEN : 0);
      check($sformatf("R2 vec%0d ext low cycles", i), ext_cnt, VECS[i].core ? EXT_LEN : 0);
      check($sformatf("R5 vec%0d ovf_flag", i), ovf_flag, int'(VECS[i].ovf));
      check($sformatf("R6 vec%0d src flag", i), pin_src_flag, VECS[i].core ? 0 : 1);
    end

    // R5, R2: flag and both pulses start together; flag holds during the sequence
    pin_reset();
    do_write(1'b1, 8'h07);
    do_write(1'b0, 8'hFF);
    clear_tally();
    @(negedge clk); cnt_tick = 1'b1;
    @(negedge clk); cnt_tick = 1'b0;
    check("R2 ext low at start", ext_rst_n_o, 0);
    check("R1 core high at start", core_rst, 1);
    check("R5 ovf set at start", ovf_flag, 1);
    repeat (300) @(negedge clk);
    check("R5 ovf held during sequence", ovf_flag, 1);
    check("R2 ext released before core", ext_rst_n_o, 1);
    // R10 writes during the sequence have no effect
    do_write(1'b1, 8'h07);
    do_write(1'b0, 8'hFF);
    give_ticks(5);
    repeat (300) @(negedge clk);
    check("R10 no retrigger core cycles", core_cnt, RST_LEN);
    check("R5 ovf cleared at end", ovf_flag, 0);
    clear_tally();
    give_ticks(300);
    repeat (20) @(negedge clk);
    check("R10 control cleared, no overflow", ovf_flag, 0);
    check("R10 control cleared, no reset", core_cnt, 0);

    // R7 tie: pin low in the overflow cycle
    pin_reset();
    do_write(1'b1, 8'h07);
    do_write(1'b0, 8'hFF);
    clear_tally();
    @(negedge clk); pin_rst_n = 1'b0; cnt_tick = 1'b1;
    @(negedge clk); cnt_tick = 1'b0;
    repeat (2) @(negedge clk);
    pin_rst_n = 1'b1;
    repeat (10) @(negedge clk);
    check("R7 tie core cycles", core_cnt, 0);
    check("R7 tie src flag", pin_src_flag, 1);
    check("R7 tie ovf flag", ovf_flag, 0);

    // R9 counter write wins over a tick in the same cycle
    pin_reset();
    do_write(1'b1, 8'h03);
    do_write(1'b0, 8'hFF);
    clear_tally();
    @(negedge clk); cnt_tick = 1'b1; wr_en = 1'b1; wr_sel = 1'b0; wr_data = 8'h00;
    @(negedge clk); cnt_tick = 1'b0; wr_en = 1'b0;
    repeat (5) @(negedge clk);
    check("R9 service write beats tick nmi", nmi_cnt, 0);
    check("R9 service write beats tick ovf", ovf_flag, 0);
    give_ticks(255);
    repeat (3) @(negedge clk);
    check("R9 serviced counter 255 ticks no wrap", nmi_cnt, 0);
    give_ticks(1);
    repeat (3) @(negedge clk);
    check("R9 serviced counter wraps at 256", nmi_cnt, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule